// File: doc/BRIEF.md
# Two-Stage Locked Watchdog Timer

This block is a watchdog peripheral on a simple register bus. Software arms it by setting an enable bit. From then on it must keep sending a restart command before the timer runs out. The countdown has two stages, each loaded from its own preload register. When the first stage runs out, the block raises an interrupt and starts the second stage. If the second stage also runs out, a sticky timeout flag is set and a reset request is driven out of the block. A prescaler derives the countdown tick from the system clock, at one of two rates.

The preload registers and the restart command are guarded by a key sequence. Two writes to the control/status register, first 0x80 and then 0x86 in the low byte, open the guard for exactly one protected write. A separate lock bit freezes the enable state, so that once the watchdog is armed and locked, software cannot stop it. A free-running mode uses the same two stages as a periodic interrupt source and never requests a reset.

Top module: `wdog_twostage`

## Requirements
- R1: After reset, the registers read as follows: configuration (word 0) = 0, control (word 1) = 0, both preloads (words 2 and 3) = all ones in PRE_W bits, status (word 4) = 0. The outputs irq and wdt_rst are 0. A read returns data one cycle after the rd strobe.
- R2: Two writes to word 4 open the guard: the first with be[0]=1 and low byte 0x80, the next with be[0]=1 and low byte 0x86. The next write to word 2, 3 or 4 is then accepted and closes the guard again.
- R3: While the guard is not open, a write to word 2, 3 or 4 has no protected effect. A write to word 4 made after 0x80 whose low byte is not 0x86 returns the key sequence to its start.
- R4: In word 1, bit 0 is lock, bit 1 is enable and bit 2 selects free-running mode. Once bit 0 is 1, every write to word 1 is ignored until reset, so the timer keeps counting.
- R5: While the block is enabled, a countdown tick occurs every 2^SLOW_LOG clock cycles when configuration bit 2 is 0, and every 2^FAST_LOG cycles when it is 1. The tick phase restarts on enable and on every restart command.
- R6: Stage one starts at preload A and decrements on each tick. On the tick where its count is already 0, the block switches to stage two, loaded with preload B. At that point irq goes to 1 and irq_kind takes configuration bits 1:0, unless those bits are 11, which suppresses the interrupt.
- R7: In watchdog mode (word 1 bit 2 = 0), when stage two expires, status bit 9 is set and the countdown halts. wdt_rst is also set if configuration bit 5 is 0.
- R8: A guarded write to word 4 with bit 8 set (be[1]=1) restarts stage one from preload A and clears irq.
- R9: Status bit 9 and wdt_rst are cleared only by a guarded restart write that has bits 9 and 8 both set. A restart with bit 8 alone leaves both set.
- R10: In free-running mode, expiry of stage two restarts stage one from preload A. No flag is set and no reset is requested.
- R11: While enable is 0, the countdown is held at the start of stage one and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register word address |
| wr | input | 1 | Write strobe |
| be | input | 4 | Byte enables for wdata |
| wdata | input | 32 | Write data |
| rd | input | 1 | Read strobe |
| rdata | output | 32 | Read data, valid the cycle after rd |
| irq | output | 1 | First-stage expiry interrupt |
| irq_kind | output | 2 | Interrupt type captured at first-stage expiry |
| wdt_rst | output | 1 | Reset request after second-stage expiry |

## Verification
The bench targets the key sequence. One case writes a preload with no unlock, one reuses an unlock that has already been consumed, and one breaks the sequence with a wrong second key. A design that counted keys loosely would let each of these writes change a preload. The bench checks that a restart without bit 9 leaves the flag and reset request set, and that a locked control register refuses to disable the timer. A design that cleared state too eagerly would drop the reset request, and one that ignored the lock would stop counting. A cycle-level model also measures the exact expiry edges at both prescaler rates, with interrupt type 11 and with the reset output masked. An off-by-one in the tick or the stage switch shows up as an early or late edge on irq or wdt_rst.

// File: rtl/wdog_twostage.sv
module wdog_twostage #(
  parameter int PRE_W    = 20,
  parameter int SLOW_LOG = 15,
  parameter int FAST_LOG = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic        rd,
  output logic [31:0] rdata,
  output logic        irq,
  output logic [1:0]  irq_kind,
  output logic        wdt_rst
);
  localparam logic [2:0] W_CFG = 3'd0, W_CTL = 3'd1, W_PA = 3'd2, W_PB = 3'd3, W_STAT = 3'd4;
  localparam logic [7:0] KEY_ONE = 8'h80, KEY_TWO = 8'h86;
  localparam int PAD = 32 - PRE_W;

  typedef enum logic [1:0] {UL_IDLE, UL_ARMED, UL_OPEN} ul_t;
  typedef enum logic [1:0] {ST_A, ST_B, ST_HALT} st_t;

  logic [5:0]          cfg;
  logic [2:0]          ctl;
  logic [PRE_W-1:0]    pre_a, pre_b, cnt;
  logic [SLOW_LOG-1:0] div;
  logic                flag;
  ul_t                 ul;
  st_t                 st;

  wire [31:0] wm      = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  wire [31:0] cfg_new = ({26'b0, cfg} & ~wm) | (wdata & wm);
  wire [31:0] ctl_new = ({29'b0, ctl} & ~wm) | (wdata & wm);
  wire [31:0] pa_new  = ({{PAD{1'b0}}, pre_a} & ~wm) | (wdata & wm);
  wire [31:0] pb_new  = ({{PAD{1'b0}}, pre_b} & ~wm) | (wdata & wm);

  wire open_ok  = (ul == UL_OPEN);
  wire prot     = wr && (addr == W_PA || addr == W_PB || addr == W_STAT);
  wire restart  = wr && addr == W_STAT && open_ok && be[1] && wdata[8];
  wire clear    = restart && wdata[9];
  wire en       = ctl[1];
  wire freerun  = ctl[2];
  wire tick     = cfg[2] ? &div[FAST_LOG-1:0] : &div;
  wire cnt_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg   <= '0;
      ctl   <= '0;
      pre_a <= '1;
      pre_b <= '1;
      ul    <= UL_IDLE;
    end else begin
      if (wr && addr == W_CFG) cfg <= cfg_new[5:0] & 6'h27;
      if (wr && addr == W_CTL && !ctl[0]) ctl <= ctl_new[2:0];
      if (wr && addr == W_PA && open_ok) pre_a <= pa_new[PRE_W-1:0];
      if (wr && addr == W_PB && open_ok) pre_b <= pb_new[PRE_W-1:0];
      if (prot) begin
        if (open_ok || addr != W_STAT || !be[0]) ul <= UL_IDLE;
        else if (ul == UL_IDLE) ul <= (wdata[7:0] == KEY_ONE) ? UL_ARMED : UL_IDLE;
        else ul <= (wdata[7:0] == KEY_TWO) ? UL_OPEN : UL_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div      <= '0;
      cnt      <= '1;
      st       <= ST_A;
      irq      <= 1'b0;
      irq_kind <= 2'b00;
      flag     <= 1'b0;
      wdt_rst  <= 1'b0;
    end else begin
      if (clear) begin
        flag    <= 1'b0;
        wdt_rst <= 1'b0;
      end
      if (!en || restart) begin
        div <= '0;
        cnt <= pre_a;
        st  <= ST_A;
        irq <= 1'b0;
      end else begin
        div <= div + 1'b1;
        if (tick) begin
          case (st)
            ST_A:
              if (cnt_zero) begin
                st  <= ST_B;
                cnt <= pre_b;
                if (cfg[1:0] != 2'b11) begin
                  irq      <= 1'b1;
                  irq_kind <= cfg[1:0];
                end
              end else cnt <= cnt - 1'b1;
            ST_B:
              if (cnt_zero) begin
                if (freerun) begin
                  st  <= ST_A;
                  cnt <= pre_a;
                end else begin
                  st   <= ST_HALT;
                  flag <= 1'b1;
                  if (!cfg[5]) wdt_rst <= 1'b1;
                end
              end else cnt <= cnt - 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd) begin
      case (addr)
        W_CFG:   rdata <= {26'b0, cfg};
        W_CTL:   rdata <= {29'b0, ctl};
        W_PA:    rdata <= {{PAD{1'b0}}, pre_a};
        W_PB:    rdata <= {{PAD{1'b0}}, pre_b};
        W_STAT:  rdata <= {22'b0, flag, 9'b0};
        default: rdata <= '0;
      endcase
    end
  end

  a_r2_unlock_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (prot && open_ok) |=> (ul == UL_IDLE));
  a_r3_closed_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == W_PA && !open_ok) |=> $stable(pre_a));
  a_r4_lock_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[0] |=> $stable(ctl));
  a_r7_rst_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> flag);
  a_r8_restart_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !irq);
  a_r9_clear_both: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!flag && !wdt_rst));
  a_r10_freerun_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> !$past(freerun));
  a_r11_idle_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq);
endmodule

// File: tb/wdog_twostage_test.sv
module wdog_twostage_test;
  localparam int CLK_P = 10;
  localparam int SLOW  = 8;
  localparam int FAST  = 3;
  localparam int PW    = 20;
  localparam int PMAX  = (1 << PW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [2:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wdt_rst;
  logic [1:0]  irq_kind;

  always #(CLK_P/2) clk = ~clk;

  wdog_twostage #(.PRE_W(PW), .SLOW_LOG(SLOW), .FAST_LOG(FAST)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .be(be), .wdata(wdata),
    .rd(rd), .rdata(rdata), .irq(irq), .irq_kind(irq_kind), .wdt_rst(wdt_rst));

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  string cur_req = "R1";

  // behavioural reference model
  int m_cfg, m_ctl, m_pa, m_pb, m_ul, m_div, m_cnt, m_st, m_kind;
  logic m_irq, m_flag, m_rst;
  logic [31:0] m_rdata;
  bit is_rs, tk;

  function automatic int mrg(int old, logic [3:0] b, logic [31:0] d);
    int r = old;
    for (int i = 0; i < 4; i++)
      if (b[i]) begin
        r = r & ~(255 << (8 * i));
        r = r | (int'(d[8*i +: 8]) << (8 * i));
      end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 0; m_ctl = 0; m_pa = PMAX; m_pb = PMAX; m_ul = 0; m_div = 0;
      m_cnt = PMAX; m_st = 0; m_irq = 0; m_kind = 0; m_flag = 0; m_rst = 0; m_rdata = '0;
    end else begin
      is_rs = wr && addr == 3'd4 && m_ul == 2 && be[1] && wdata[8];
      if (rd) begin
        case (addr)
          3'd0: m_rdata = 32'(m_cfg);
          3'd1: m_rdata = 32'(m_ctl);
          3'd2: m_rdata = 32'(m_pa);
          3'd3: m_rdata = 32'(m_pb);
          3'd4: m_rdata = m_flag ? 32'h200 : 32'h0;
          default: m_rdata = '0;
        endcase
      end
      if (is_rs && wdata[9]) begin m_flag = 0; m_rst = 0; end
      if ((m_ctl & 2) == 0 || is_rs) begin
        m_div = 0; m_cnt = m_pa; m_st = 0; m_irq = 0;
      end else begin
        tk = (m_cfg & 4) != 0 ? (m_div % (1 << FAST)) == (1 << FAST) - 1
                              : m_div == (1 << SLOW) - 1;
        m_div = (m_div + 1) % (1 << SLOW);
        if (tk) begin
          if (m_st == 0) begin
            if (m_cnt == 0) begin
              m_st = 1; m_cnt = m_pb;
              if ((m_cfg & 3) != 3) begin m_irq = 1; m_kind = m_cfg & 3; end
            end else m_cnt--;
          end else if (m_st == 1) begin
            if (m_cnt == 0) begin
              if ((m_ctl & 4) != 0) begin m_st = 0; m_cnt = m_pa; end
              else begin m_st = 2; m_flag = 1; if ((m_cfg & 32) == 0) m_rst = 1; end
            end else m_cnt--;
          end
        end
      end
      if (wr) begin
        case (addr)
          3'd0: m_cfg = mrg(m_cfg, be, wdata) & 'h27;
          3'd1: if ((m_ctl & 1) == 0) m_ctl = mrg(m_ctl, be, wdata) & 7;
          3'd2: if (m_ul == 2) m_pa = mrg(m_pa, be, wdata) & PMAX;
          3'd3: if (m_ul == 2) m_pb = mrg(m_pb, be, wdata) & PMAX;
          default: ;
        endcase
        if (addr >= 3'd2 && addr <= 3'd4) begin
          if (m_ul == 2 || addr != 3'd4 || !be[0]) m_ul = 0;
          else if (m_ul == 0) m_ul = (wdata[7:0] == 8'h80) ? 1 : 0;
          else m_ul = (wdata[7:0] == 8'h86) ? 2 : 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      vectors++;
      if (irq !== m_irq || wdt_rst !== m_rst || (m_irq && irq_kind !== 2'(m_kind)) ||
          rdata !== m_rdata) begin
        miscompares++;
        $display("FAIL %s per-cycle: irq=%0b exp %0b, wdt_rst=%0b exp %0b, kind=%0d exp %0d, rdata=%h exp %h",
                 cur_req, irq, m_irq, wdt_rst, m_rst, irq_kind, m_kind, rdata, m_rdata);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bw(input logic [2:0] a, input logic [3:0] b, input logic [31:0] d);
    addr = a; be = b; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; be = '0;
  endtask

  task automatic unlock();
    bw(3'd4, 4'h1, 32'h80);
    bw(3'd4, 4'h1, 32'h86);
  endtask

  task automatic pw(input logic [2:0] a, input logic [31:0] d);
    unlock();
    bw(a, 4'hF, d);
  endtask

  task automatic rchk(input string req, input logic [2:0] a, input logic [31:0] exp);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk(req, rdata, exp);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish, got hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 wdt_rst", {31'b0, wdt_rst}, 0);
    rchk("R1 cfg", 3'd0, 0);
    rchk("R1 ctl", 3'd1, 0);
    rchk("R1 preA", 3'd2, PMAX);
    rchk("R1 preB", 3'd3, PMAX);
    rchk("R1 status", 3'd4, 0);

    cur_req = "R3";
    bw(3'd2, 4'hF, 32'd5);
    rchk("R3 write without unlock", 3'd2, PMAX);

    cur_req = "R2";
    pw(3'd2, 32'd3);
    rchk("R2 unlocked preA write", 3'd2, 3);
    pw(3'd3, 32'd2);
    rchk("R2 unlocked preB write", 3'd3, 2);

    cur_req = "R3";
    bw(3'd2, 4'hF, 32'd9);
    rchk("R3 reuse of consumed unlock", 3'd2, 3);
    bw(3'd4, 4'h1, 32'h80); bw(3'd4, 4'h1, 32'h55); bw(3'd4, 4'h1, 32'h86);
    bw(3'd2, 4'hF, 32'd9);
    rchk("R3 broken key sequence", 3'd2, 3);

    cur_req = "R6";
    bw(3'd0, 4'hF, 32'h05);
    rchk("R6 cfg readback", 3'd0, 32'h05);
    bw(3'd1, 4'hF, 32'h2);
    wait_n(40);
    chk("R6 irq after stage one", {31'b0, irq}, 1);
    chk("R6 irq_kind", {30'b0, irq_kind}, 1);
    chk("R5 no reset yet", {31'b0, wdt_rst}, 0);
    cur_req = "R7";
    wait_n(30);
    chk("R7 reset after stage two", {31'b0, wdt_rst}, 1);
    rchk("R7 timeout flag", 3'd4, 32'h200);

    cur_req = "R9";
    pw(3'd4, 32'h100);
    rchk("R9 flag kept by plain restart", 3'd4, 32'h200);
    chk("R9 reset kept by plain restart", {31'b0, wdt_rst}, 1);
    chk("R8 irq cleared by restart", {31'b0, irq}, 0);
    pw(3'd4, 32'h300);
    rchk("R9 flag cleared", 3'd4, 0);
    chk("R9 reset cleared", {31'b0, wdt_rst}, 0);

    cur_req = "R8";
    for (int i = 0; i < 5; i++) begin
      wait_n(20);
      pw(3'd4, 32'h100);
    end
    chk("R8 restarts prevent irq", {31'b0, irq}, 0);
    chk("R8 restarts prevent reset", {31'b0, wdt_rst}, 0);

    cur_req = "R6";
    bw(3'd0, 4'hF, 32'h07);
    pw(3'd4, 32'h100);
    wait_n(45);
    chk("R6 type 11 suppresses irq", {31'b0, irq}, 0);
    wait_n(30);
    chk("R7 reset with irq suppressed", {31'b0, wdt_rst}, 1);
    pw(3'd4, 32'h300);

    cur_req = "R7";
    bw(3'd0, 4'hF, 32'h25);
    pw(3'd4, 32'h100);
    wait_n(75);
    chk("R7 masked reset output", {31'b0, wdt_rst}, 0);
    rchk("R7 flag still set when masked", 3'd4, 32'h200);
    pw(3'd4, 32'h300);

    cur_req = "R10";
    bw(3'd0, 4'hF, 32'h05);
    bw(3'd1, 4'hF, 32'h6);
    wait_n(200);
    chk("R10 no reset in free-running", {31'b0, wdt_rst}, 0);
    rchk("R10 no flag in free-running", 3'd4, 0);
    chk("R10 irq fires", {31'b0, irq}, 1);

    cur_req = "R11";
    bw(3'd1, 4'hF, 32'h0);
    wait_n(1);
    chk("R11 disable clears irq", {31'b0, irq}, 0);
    wait_n(100);
    chk("R11 held while disabled", {31'b0, irq | wdt_rst}, 0);

    cur_req = "R5";
    bw(3'd0, 4'hF, 32'h00);
    pw(3'd2, 32'd1);
    pw(3'd3, 32'd0);
    bw(3'd1, 4'hF, 32'h2);
    wait_n(500);
    chk("R5 slow rate no irq yet", {31'b0, irq}, 0);
    wait_n(20);
    chk("R5 slow rate irq", {31'b0, irq}, 1);
    wait_n(260);
    chk("R5 slow rate reset", {31'b0, wdt_rst}, 1);
    pw(3'd4, 32'h300);

    cur_req = "R4";
    bw(3'd1, 4'hF, 32'h3);
    bw(3'd1, 4'hF, 32'h0);
    rchk("R4 locked control unchanged", 3'd1, 32'h3);
    wait_n(530);
    chk("R4 still counting when locked", {31'b0, irq}, 1);

    wait_n(2);
    summary();
  end
endmodule